// File: doc/BRIEF.md
# Bus-Master Disk DMA Engine

This block is the host side of a disk bus-master DMA channel. Software programs a 32-bit pointer to a table of 8-byte region descriptors in memory, then sets the start bit in the command byte. The engine reads each descriptor as two dword reads. It then moves 16-bit data words between the drive's data stream and the described memory regions over a simple request/acknowledge memory master.

The drive signals that it wants to move more words by holding a request line. The engine accepts one word per acknowledge pulse. After the drive has finished its data, it raises an interrupt line. The status byte reports how the total of the region descriptors compared with the drive's transfer:

- **Short table:** Active and Interrupt are both clear.
- **Exact match:** Interrupt is set and Active is clear.
- **Longer table:** Active and Interrupt are both set.

Clearing the start bit halts the engine at once. A memory error response sets the Error bit and ends the run.

Top module: `bmide_dma`

## Requirements
- R1: After reset the command byte, the status byte and the table pointer read as zero, and no memory request is made.
- R2: Writing the command byte with bit 0 going from 0 to 1 makes the engine read the descriptor's address dword at the table pointer, then its count dword at the pointer plus 4.
- R3: With command bit 3 set, words move from the drive into memory. A word at byte address A is written to the dword at A with bits 1:0 cleared, using byte enables 4'b0011 when A[1] is 0 and 4'b1100 when A[1] is 1.
- R4: With command bit 3 clear, words are read from memory on the same lanes and handed to the drive one cycle after the read is acknowledged.
- R5: The byte count is bits 15:0 of the second descriptor dword. Its bit 0 is ignored, and a count of zero stands for 65536 bytes.
- R6: Descriptors are consumed in table order, 8 bytes apart. Bit 31 of the count dword marks the final descriptor.
- R7: When the table total equals the drive's transfer, status bit 0 (Active) reads 0 once the table is exhausted. A later rising drive interrupt sets status bit 2 (Interrupt).
- R8: When the table runs out while the drive still requests, Active clears, no further memory request is made, and a drive interrupt does not set Interrupt.
- R9: When the drive stops requesting before the table total is used, Active stays 1 and a rising drive interrupt sets Interrupt, so the status reads 0x05.
- R10: Writing the command byte with bit 0 clear while running stops memory requests and drive acknowledges from the next cycle and clears Active. A later drive interrupt still sets Interrupt.
- R11: Writing 1 to status bit 2 clears Interrupt. Writing 0 to it leaves it unchanged.
- R12: A memory error response sets status bit 1 (Error) and clears Active. Writing 1 to status bit 1 clears it.
- R13: Register offsets: 0 is the command byte (bits 0 and 3 read back), 2 is the status byte, and 4 is the table pointer, whose bits 1:0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Dword-aligned memory byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request accepted this cycle |
| mem_err | input | 1 | Error response with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_req | input | 1 | Drive has more words to move |
| dev_ack | output | 1 | One word moved this cycle |
| dev_rdata | input | 16 | Word from the drive |
| dev_wdata | output | 16 | Word to the drive |
| drv_irq | input | 1 | Drive interrupt |

## Verification
A wrong walk state shows up at the memory port within one request. A misplaced descriptor fetch, a wrong lane enable or a missed end-of-table flag writes the wrong memory word, or hands the drive the wrong word, on that same acknowledge. Miscounted region sizes surface only at the end of a job, as a status byte of 0x00, 0x04 or 0x05 differing from the one the table-versus-transfer comparison predicts. The bench therefore reads status both before and after the drive interrupt. A broken halt or error path shows as memory traffic that continues in the cycle after the command write or the error response.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;
   localparam logic [2:0] OFS_PTR  = 3'd4;

   localparam int CMD_GO    = 0;
   localparam int CMD_TOMEM = 3;
   localparam int ST_ACT    = 0;
   localparam int ST_ERR    = 1;
   localparam int ST_INT    = 2;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_DESC_LO,
      WK_DESC_HI,
      WK_MOVE,
      WK_PUSH,
      WK_OVER,
      WK_UNDER
   } wk_state_e;
endpackage

// File: rtl/bmd_regs.sv
module bmd_regs
   import bmd_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              active,
   input  logic              intr_set,
   input  logic              err_set,
   output logic              go_pulse,
   output logic              halt_pulse,
   output logic              to_mem,
   output logic [ADDR_W-1:0] tbl_base
);
   logic go_q, tomem_q, int_q, err_q;
   logic [ADDR_W-1:0] base_q;
   logic cmd_wr, stat_wr, ptr_wr;
   logic unused_wbits;

   assign cmd_wr  = reg_wr && (reg_addr == OFS_CMD);
   assign stat_wr = reg_wr && (reg_addr == OFS_STAT);
   assign ptr_wr  = reg_wr && (reg_addr == OFS_PTR);

   assign go_pulse   = cmd_wr &&  reg_wdata[CMD_GO] && !go_q;
   assign halt_pulse = cmd_wr && !reg_wdata[CMD_GO] &&  go_q;
   assign to_mem     = tomem_q;
   assign tbl_base   = base_q;
   assign unused_wbits = ^{reg_wdata[31:ADDR_W], reg_wdata[1:0]} ^ ^reg_wdata[7:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q    <= 1'b0;
         tomem_q <= 1'b0;
         int_q   <= 1'b0;
         err_q   <= 1'b0;
         base_q  <= '0;
      end else begin
         if (cmd_wr) begin
            go_q    <= reg_wdata[CMD_GO];
            tomem_q <= reg_wdata[CMD_TOMEM];
         end
         if (ptr_wr)
            base_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
         if (intr_set)
            int_q <= 1'b1;
         else if (stat_wr && reg_wdata[ST_INT])
            int_q <= 1'b0;
         if (err_set)
            err_q <= 1'b1;
         else if (stat_wr && reg_wdata[ST_ERR])
            err_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CMD: begin
            reg_rdata[CMD_GO]    = go_q;
            reg_rdata[CMD_TOMEM] = tomem_q;
         end
         OFS_STAT: begin
            reg_rdata[ST_ACT] = active;
            reg_rdata[ST_ERR] = err_q;
            reg_rdata[ST_INT] = int_q;
         end
         OFS_PTR: reg_rdata = 32'(base_q);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/bmd_lane.sv
module bmd_lane #(
   parameter int MEM_W = 32,
   parameter int HW_W  = 16
) (
   input  logic [$clog2(MEM_W/8)-1:0] sel_addr,
   input  logic [HW_W-1:0]            wr_hw,
   input  logic [MEM_W-1:0]           rd_word,
   output logic [MEM_W/8-1:0]         be,
   output logic [MEM_W-1:0]           wr_word,
   output logic [HW_W-1:0]            rd_hw
);
   localparam int LANES = MEM_W / HW_W;
   localparam int HB    = HW_W / 8;
   localparam int MB_W  = $clog2(MEM_W/8);
   localparam int HB_W  = $clog2(HB);

   logic unused_low;
   assign unused_low = ^sel_addr[HB_W-1:0];
   assign wr_word = {LANES{wr_hw}};

   generate
      if (LANES == 1) begin : g_one
         logic unused_sel;
         assign unused_sel = ^sel_addr;
         assign be    = '1;
         assign rd_hw = rd_word;
      end else begin : g_many
         logic [MB_W-HB_W-1:0] lane;
         assign lane  = sel_addr[MB_W-1:HB_W];
         assign rd_hw = rd_word[lane*HW_W +: HW_W];
         for (genvar g = 0; g < LANES; g++) begin : g_be
            assign be[g*HB +: HB] = {HB{lane == g}};
         end
      end
   endgenerate
endmodule

// File: rtl/bmd_walker.sv
module bmd_walker
   import bmd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int MEM_W  = 32,
   parameter int HW_W   = 16,
   parameter int CNT_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_pulse,
   input  logic               halt_pulse,
   input  logic               to_mem,
   input  logic [ADDR_W-1:0]  tbl_base,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [MEM_W/8-1:0] mem_be,
   output logic [MEM_W-1:0]   mem_wdata,
   input  logic               mem_ack,
   input  logic               mem_err,
   input  logic [MEM_W-1:0]   mem_rdata,
   input  logic               dev_req,
   output logic               dev_ack,
   input  logic [HW_W-1:0]    dev_rdata,
   output logic [HW_W-1:0]    dev_wdata,
   output logic               active,
   output logic               irq_ok,
   output logic               err_set
);
   localparam int HB    = HW_W / 8;
   localparam int HB_W  = $clog2(HB);
   localparam int MB_W  = $clog2(MEM_W/8);
   localparam int REM_W = CNT_W + 1;
   localparam logic [REM_W-1:0]  REM_FULL = {1'b1, {CNT_W{1'b0}}};
   localparam logic [REM_W-1:0]  REM_STEP = REM_W'(HB);
   localparam logic [ADDR_W-1:0] BUF_STEP = ADDR_W'(HB);

   wk_state_e         st_q;
   logic [ADDR_W-1:0] ptr_q, buf_q;
   logic [REM_W-1:0]  rem_q, rem_load;
   logic              last_q;
   logic [HW_W-1:0]   hold_q, lane_rd;
   logic [CNT_W-1:0]  cnt_even;
   logic [MEM_W/8-1:0] lane_be;
   logic              exhausted, data_go, acked;
   logic              unused_rd;

   assign unused_rd = ^mem_rdata[MEM_W-2:CNT_W];

   bmd_lane #(.MEM_W(MEM_W), .HW_W(HW_W)) u_lane (
      .sel_addr (buf_q[MB_W-1:0]),
      .wr_hw    (dev_rdata),
      .rd_word  (mem_rdata),
      .be       (lane_be),
      .wr_word  (mem_wdata),
      .rd_hw    (lane_rd)
   );

   assign cnt_even  = {mem_rdata[CNT_W-1:HB_W], {HB_W{1'b0}}};
   assign rem_load  = (cnt_even == '0) ? REM_FULL : {1'b0, cnt_even};
   assign exhausted = (rem_q == '0) && last_q;
   assign data_go   = (st_q == WK_MOVE) && !exhausted && dev_req && (rem_q != '0);
   assign acked     = mem_req && mem_ack;

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = ptr_q;
      mem_be   = '1;
      case (st_q)
         WK_DESC_LO: mem_req = 1'b1;
         WK_DESC_HI: begin
            mem_req  = 1'b1;
            mem_addr = ptr_q + ADDR_W'(4);
         end
         WK_MOVE: begin
            mem_req  = data_go;
            mem_we   = to_mem;
            mem_addr = {buf_q[ADDR_W-1:MB_W], {MB_W{1'b0}}};
            mem_be   = lane_be;
         end
         default: ;
      endcase
   end

   assign dev_ack = !halt_pulse &&
                    ((data_go && to_mem && mem_ack && !mem_err) || (st_q == WK_PUSH));
   assign dev_wdata = hold_q;
   assign err_set   = acked && mem_err;
   assign active    = (st_q == WK_DESC_LO) || (st_q == WK_DESC_HI) || (st_q == WK_MOVE) ||
                      (st_q == WK_PUSH) || (st_q == WK_OVER);
   assign irq_ok    = (st_q != WK_UNDER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WK_IDLE;
         ptr_q  <= '0;
         buf_q  <= '0;
         rem_q  <= '0;
         last_q <= 1'b0;
         hold_q <= '0;
      end else if (halt_pulse) begin
         st_q <= WK_IDLE;
      end else begin
         case (st_q)
            WK_IDLE: if (go_pulse) begin
               ptr_q <= tbl_base;
               st_q  <= WK_DESC_LO;
            end
            WK_DESC_LO: if (mem_ack) begin
               if (mem_err) st_q <= WK_IDLE;
               else begin
                  buf_q <= {mem_rdata[ADDR_W-1:HB_W], {HB_W{1'b0}}};
                  st_q  <= WK_DESC_HI;
               end
            end
            WK_DESC_HI: if (mem_ack) begin
               if (mem_err) st_q <= WK_IDLE;
               else begin
                  rem_q  <= rem_load;
                  last_q <= mem_rdata[MEM_W-1];
                  ptr_q  <= ptr_q + ADDR_W'(8);
                  st_q   <= WK_MOVE;
               end
            end
            WK_MOVE: begin
               if (exhausted)
                  st_q <= dev_req ? WK_UNDER : WK_IDLE;
               else if (!dev_req)
                  st_q <= WK_OVER;
               else if (rem_q == '0)
                  st_q <= WK_DESC_LO;
               else if (mem_ack) begin
                  if (mem_err) st_q <= WK_IDLE;
                  else if (to_mem) begin
                     rem_q <= rem_q - REM_STEP;
                     buf_q <= buf_q + BUF_STEP;
                  end else begin
                     hold_q <= lane_rd;
                     st_q   <= WK_PUSH;
                  end
               end
            end
            WK_PUSH: begin
               rem_q <= rem_q - REM_STEP;
               buf_q <= buf_q + BUF_STEP;
               st_q  <= WK_MOVE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bmide_dma.sv
module bmide_dma #(
   parameter int ADDR_W = 32,
   parameter int MEM_W  = 32,
   parameter int HW_W   = 16,
   parameter int CNT_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [MEM_W/8-1:0] mem_be,
   output logic [MEM_W-1:0]   mem_wdata,
   input  logic               mem_ack,
   input  logic               mem_err,
   input  logic [MEM_W-1:0]   mem_rdata,
   input  logic               dev_req,
   output logic               dev_ack,
   input  logic [HW_W-1:0]    dev_rdata,
   output logic [HW_W-1:0]    dev_wdata,
   input  logic               drv_irq
);
   generate
      if (MEM_W != 32) begin : g_bad_mem
         $error("descriptors are two dwords: MEM_W must be 32");
      end
      if (HW_W < 16 || (MEM_W % HW_W) != 0) begin : g_bad_hw
         $error("HW_W must be at least 16 and divide MEM_W");
      end
      if (CNT_W >= 31 || CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W must leave room for the end-of-table bit");
      end
      if (ADDR_W > 32 || ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
   endgenerate

   logic              go_pulse, halt_pulse, to_mem, active, irq_ok, err_set;
   logic              irq_q, irq_rise, intr_set;
   logic [ADDR_W-1:0] tbl_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= drv_irq;
   end
   assign irq_rise = drv_irq && !irq_q;
   assign intr_set = irq_rise && irq_ok;

   bmd_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .active     (active),
      .intr_set   (intr_set),
      .err_set    (err_set),
      .go_pulse   (go_pulse),
      .halt_pulse (halt_pulse),
      .to_mem     (to_mem),
      .tbl_base   (tbl_base)
   );

   bmd_walker #(.ADDR_W(ADDR_W), .MEM_W(MEM_W), .HW_W(HW_W), .CNT_W(CNT_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_pulse   (go_pulse),
      .halt_pulse (halt_pulse),
      .to_mem     (to_mem),
      .tbl_base   (tbl_base),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_be     (mem_be),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_err    (mem_err),
      .mem_rdata  (mem_rdata),
      .dev_req    (dev_req),
      .dev_ack    (dev_ack),
      .dev_rdata  (dev_rdata),
      .dev_wdata  (dev_wdata),
      .active     (active),
      .irq_ok     (irq_ok),
      .err_set    (err_set)
   );
endmodule

// File: rtl/bmide_dma_chk.sv
module bmide_dma_chk #(
   parameter int MEM_W = 32,
   parameter int HW_W  = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [2:0]         reg_addr,
   input logic [2:0]         reg_wbits,
   input logic [2:0]         reg_rbits,
   input logic               mem_req,
   input logic               mem_we,
   input logic               mem_ack,
   input logic               mem_err,
   input logic [MEM_W/8-1:0] mem_be,
   input logic               dev_ack,
   input logic               irq_rise
);
   // R10
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd0 && !reg_wbits[0]) |=> (!mem_req && !dev_ack));

   // R11
   int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd2 && reg_wbits[2] && !irq_rise) |=>
      (reg_addr != 3'd2 || !reg_rbits[2]));

   // R3
   lane_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ($countones(mem_be) == HW_W/8));

   // R4
   push_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack && !mem_req) |-> $past(mem_req && mem_ack && !mem_we));

   // R12
   err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=>
      (reg_addr != 3'd2 || (reg_rbits[1] && !reg_rbits[0])));
endmodule

bind bmide_dma bmide_dma_chk #(.MEM_W(MEM_W), .HW_W(HW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wbits (reg_wdata[2:0]),
   .reg_rbits (reg_rdata[2:0]),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_err   (mem_err),
   .mem_be    (mem_be),
   .dev_ack   (dev_ack),
   .irq_rise  (irq_rise)
);

// File: tb/sim_bmide_dma.sv
module sim_bmide_dma;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack, mem_err;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic        dev_req, dev_ack;
   logic [15:0] dev_rdata, dev_wdata;
   logic        drv_irq = 1'b0;

   logic [31:0] mem [0:1023];
   logic [15:0] dev_got [0:255];
   int          dev_left = 0;
   int          dev_idx = 0;
   logic [15:0] dev_base = 16'h0;
   int          wr_cnt = 0;
   int          rd_n = 0;
   logic [31:0] rd_log [0:1];
   logic        err_on = 1'b0;
   logic [31:0] err_at = '0;

   int n_chk = 0;
   int n_bad = 0;
   logic finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   bmide_dma u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
      .dev_wdata(dev_wdata), .drv_irq(drv_irq)
   );

   assign mem_ack   = mem_req;
   assign mem_err   = mem_req && err_on && (mem_addr == err_at);
   assign mem_rdata = mem[mem_addr[11:2]];
   assign dev_req   = (dev_left != 0);
   assign dev_rdata = dev_base + 16'(dev_idx);

   always @(posedge clk) begin
      if (mem_req && mem_ack && !mem_err) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            wr_cnt <= wr_cnt + 1;
         end else if (rd_n < 2) begin
            rd_log[rd_n[0]] <= mem_addr;
            rd_n <= rd_n + 1;
         end
      end
      if (dev_ack) begin
         dev_got[dev_idx[7:0]] <= dev_wdata;
         dev_idx  <= dev_idx + 1;
         dev_left <= dev_left - 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse_irq();
      @(negedge clk); drv_irq = 1'b1;
      @(negedge clk); drv_irq = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic prep(input logic tomem, input logic [31:0] ptr, input int n, input logic [15:0] base);
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h6);
      @(negedge clk);
      dev_left = n; dev_idx = 0; rd_n = 0; wr_cnt = 0; dev_base = base;
      wr(3'd4, ptr);
      wr(3'd0, tomem ? 32'h9 : 32'h1);
   endtask

   task automatic settle();
      logic [31:0] s;
      s = 32'h1;
      for (int i = 0; i < 40000; i++) begin
         rd(3'd2, s);
         if (s[0] == 1'b0 || dev_left == 0) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(3'd2, v); chk("R1 status", v, 32'h0);
      rd(3'd0, v); chk("R1 command", v, 32'h0);
      rd(3'd4, v); chk("R1 pointer", v, 32'h0);
      chk("R1 mem_req", {31'd0, mem_req}, 32'h0);
   endtask

   task automatic t_rx_equal();
      logic [31:0] v;
      wr(3'd4, 32'h103);
      rd(3'd4, v); chk("R13 pointer low bits", v, 32'h100);
      mem[10'h40] = 32'h0000_0202; mem[10'h41] = 32'h8000_0006;
      mem[10'h80] = 32'h0; mem[10'h81] = 32'h0;
      prep(1'b1, 32'h100, 3, 16'hA000);
      rd(3'd0, v); chk("R13 command readback", v, 32'h9);
      settle();
      chk("R2 first fetch", rd_log[0], 32'h100);
      chk("R2 second fetch", rd_log[1], 32'h104);
      chk("R3 upper lane", mem[10'h80], 32'hA000_0000);
      chk("R3 both lanes", mem[10'h81], 32'hA002_A001);
      rd(3'd2, v); chk("R7 active clear before irq", v, 32'h0);
      pulse_irq();
      rd(3'd2, v); chk("R7 interrupt set", v, 32'h4);
      wr(3'd2, 32'h0);
      rd(3'd2, v); chk("R11 write 0 keeps", v, 32'h4);
      wr(3'd2, 32'h4);
      rd(3'd2, v); chk("R11 write 1 clears", v, 32'h0);
   endtask

   task automatic t_tx_chain();
      logic [31:0] v;
      mem[10'h60] = 32'h0000_0300; mem[10'h61] = 32'h0000_0004;
      mem[10'h62] = 32'h0000_0322; mem[10'h63] = 32'h8000_0002;
      mem[10'hC0] = 32'h1111_2222; mem[10'hC8] = 32'h3333_4444;
      prep(1'b0, 32'h180, 3, 16'h0);
      settle();
      chk("R4 word0", {16'h0, dev_got[0]}, 32'h2222);
      chk("R4 word1", {16'h0, dev_got[1]}, 32'h1111);
      chk("R6 word from second entry", {16'h0, dev_got[2]}, 32'h3333);
      pulse_irq();
      rd(3'd2, v); chk("R6 chained equal status", v, 32'h4);
   endtask

   task automatic t_under();
      logic [31:0] v;
      int c;
      mem[10'h70] = 32'h0000_0240; mem[10'h71] = 32'h8000_0004;
      prep(1'b1, 32'h1C0, 5, 16'h5000);
      settle();
      rd(3'd2, v); chk("R8 status short table", v, 32'h0);
      chk("R8 writes", wr_cnt, 32'd2);
      c = wr_cnt;
      pulse_irq();
      repeat (5) @(negedge clk);
      rd(3'd2, v); chk("R8 irq ignored", v, 32'h0);
      chk("R8 no further writes", wr_cnt, c);
      chk("R8 drive still pending", dev_left, 32'd3);
   endtask

   task automatic t_over();
      logic [31:0] v;
      mem[10'h70] = 32'h0000_0240; mem[10'h71] = 32'h8000_0008;
      prep(1'b1, 32'h1C0, 2, 16'h6000);
      settle();
      rd(3'd2, v); chk("R9 active before irq", v, 32'h1);
      pulse_irq();
      rd(3'd2, v); chk("R9 status long table", v, 32'h5);
      chk("R9 writes", wr_cnt, 32'd2);
   endtask

   task automatic t_count_rules();
      logic [31:0] v;
      mem[10'h70] = 32'h0000_0240; mem[10'h71] = 32'h8000_0007;
      prep(1'b1, 32'h1C0, 3, 16'h7000);
      settle();
      pulse_irq();
      rd(3'd2, v); chk("R5 odd count equal", v, 32'h4);
      chk("R5 odd count writes", wr_cnt, 32'd3);
      mem[10'h70] = 32'h0000_0000; mem[10'h71] = 32'h8000_0000;
      prep(1'b1, 32'h1C0, 32768, 16'h0);
      settle();
      pulse_irq();
      rd(3'd2, v); chk("R5 zero count is 64K", v, 32'h4);
      chk("R5 64K writes", wr_cnt, 32'd32768);
   endtask

   task automatic t_halt();
      logic [31:0] v;
      int c;
      mem[10'h70] = 32'h0000_0240; mem[10'h71] = 32'h8000_0040;
      prep(1'b1, 32'h1C0, 32, 16'h8000);
      repeat (6) @(negedge clk);
      wr(3'd0, 32'h8);
      rd(3'd2, v); chk("R10 active cleared", v, 32'h0);
      c = wr_cnt;
      chk("R10 some words moved", {31'd0, c > 0}, 32'h1);
      repeat (10) @(negedge clk);
      chk("R10 no writes after halt", wr_cnt, c);
      pulse_irq();
      rd(3'd2, v); chk("R10 irq after halt", v, 32'h4);
   endtask

   task automatic t_error();
      logic [31:0] v;
      mem[10'h70] = 32'h0000_0240; mem[10'h71] = 32'h8000_0004;
      err_at = 32'h1C4; err_on = 1'b1;
      prep(1'b1, 32'h1C0, 2, 16'h9000);
      repeat (5) @(negedge clk);
      rd(3'd2, v); chk("R12 error set active clear", v, 32'h2);
      chk("R12 no data moved", wr_cnt, 32'd0);
      err_on = 1'b0;
      wr(3'd2, 32'h2);
      rd(3'd2, v); chk("R12 error cleared", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rx_equal();
      t_tx_chain();
      t_under();
      t_over();
      t_count_rules();
      t_halt();
      t_error();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule